// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block receives two-channel serial audio as a slave. The bit clock, the frame clock and the data line are all inputs. They are brought into the system clock domain and sampled on each rising edge of the bit clock. A four-bit format code selects the frame layout and the word length. A separate bit selects whether the sample arrives most significant bit first or least significant bit first. A delay bit moves the capture window one bit slot later. Each finished left/right pair is presented as two 24-bit words on a valid/ready output. Two select bits route the received channels to the two processing channels.

The block also watches the incoming data. It raises a zero flag once a long run of all-zero pairs has been received, so that downstream logic can mute. It pulses a fault flag whenever a frame-clock edge arrives before a full half-frame of 32 bit slots. An optional protection mode ignores such early edges, so a single glitch on the frame clock cannot break the frame. The output is back-pressured by a ready input. A presented pair holds until it is accepted. Any pair that completes while the previous one is still held is discarded.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset, `out_valid_o`, `zero_o` and `bad_frame_o` are low.
- R2: Slot 0 of a half-frame is the first bit-clock rising edge at which the frame clock differs from the accepted level. `fmt_i[1:0]` selects the layout: 00 and 11 mean I2S, with the MSB-first data starting in slot 1; 01 means left-justified, with data starting in slot 0; 10 means right-justified, with data ending in slot 31. In I2S a low frame clock marks the left half. In the other two layouts a high frame clock marks the left half.
- R3: `fmt_i[3:2]` selects the word length: 00 is 24 bits, 01 is 20, 10 is 18 and 11 is 16. The sample is left-aligned in the 24-bit output word and the unused low bits are zero.
- R4: When `lsb_first_i` is 1, the first captured bit is the sample LSB. When it is 0, the first captured bit is the MSB.
- R5: When `dly_i` is 1, the capture window starts one slot later. Window bits that would fall beyond slot 31 are not received and read as zero.
- R6: `ch1_o` carries the received right sample when `sel1_i` is 1 and the left sample otherwise. `ch2_o` carries the right sample when `sel2_i` is 1 and the left sample otherwise.
- R7: A pair is offered once the right half is closed by the next accepted frame-clock edge, provided a left half was captured just before that right half. While `out_valid_o` is high and `out_ready_i` is low, the pair stays unchanged. A pair completing in that state is dropped. `out_valid_o` falls only after a transfer.
- R8: With `zd_en_i` high, `zero_o` rises when ZERO_RUN consecutive pairs with both samples zero have been received. It falls at the first pair with a nonzero sample.
- R9: With `zd_en_i` low, `zero_o` is low from the next cycle on.
- R10: `bad_frame_o` pulses for one cycle when, after lock, the frame clock changes before 32 slots of the current half have passed. Clean frames produce no pulse.
- R11: When `prot_i` is 1, such an early edge is ignored. The half keeps counting and the captured samples are unaffected.
- R12: Halves that began before the first accepted frame-clock edge produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bclk_i | input | 1 | Serial bit clock, 64 per frame |
| frame_i | input | 1 | Left/right frame clock |
| sdata_i | input | 1 | Serial data |
| fmt_i | input | 4 | [3:2] word length, [1:0] layout |
| lsb_first_i | input | 1 | 1 = LSB arrives first |
| dly_i | input | 1 | Shift capture window one slot later |
| prot_i | input | 1 | Ignore early frame-clock edges |
| sel1_i | input | 1 | Source for channel 1 (0 left, 1 right) |
| sel2_i | input | 1 | Source for channel 2 (0 left, 1 right) |
| zd_en_i | input | 1 | Enable zero detection |
| out_valid_o | output | 1 | Pair available |
| out_ready_i | input | 1 | Consumer accepts pair |
| ch1_o | output | 24 | Processing channel 1 sample |
| ch2_o | output | 24 | Processing channel 2 sample |
| zero_o | output | 1 | Long zero run seen |
| bad_frame_o | output | 1 | Short half-frame pulse |

## Verification
A slot counter that is off by one shows up in the very next pair that is offered. The sample appears doubled or halved, or has a bit missing, so a single frame exposes it. A wrong accepted frame-clock level or a wrong lock state shows up as swapped channels, or as an extra or missing pair, within two half-frames. A zero-run counter that is off shows `zero_o` changing one pair early or one pair late. The hold logic is checked by stalling ready across several frames and comparing the pair that is finally accepted with the first frame sent.

// File: rtl/sar_pkg.sv
`timescale 1ns/1ps
package sar_pkg;
  localparam int unsigned WORD_W     = 24;
  localparam int unsigned HALF_SLOTS = 32;
  localparam int unsigned SLOT_W     = $clog2(HALF_SLOTS);
  localparam int unsigned IDX_W      = SLOT_W + 1;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    LAY_I2S = 2'b00,
    LAY_LJ  = 2'b01,
    LAY_RJ  = 2'b10,
    LAY_ALT = 2'b11
  } layout_e;

  function automatic logic [IDX_W-1:0] len_bits(input logic [1:0] code);
    case (code)
      2'b00:   return IDX_W'(24);
      2'b01:   return IDX_W'(20);
      2'b10:   return IDX_W'(18);
      default: return IDX_W'(16);
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] first_slot(input layout_e lay,
                                                  input logic [1:0] code,
                                                  input logic dly);
    logic [IDX_W-1:0] base;
    case (lay)
      LAY_LJ:  base = '0;
      LAY_RJ:  base = IDX_W'(HALF_SLOTS) - len_bits(code);
      default: base = IDX_W'(1);
    endcase
    return base + IDX_W'(dly);
  endfunction
endpackage

// File: rtl/sar_sync.sv
`timescale 1ns/1ps
module sar_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] raw_i,
  output logic       slot_stb_o,
  output logic       frame_o,
  output logic       data_o
);
  logic [2:0] synced;
  logic       bclk_prev;

  for (genvar g = 0; g < 3; g++) begin : g_line
    logic [STAGES-1:0] sr;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[STAGES-2:0], raw_i[g]};
    end
    assign synced[g] = sr[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bclk_prev <= 1'b0;
    else        bclk_prev <= synced[0];
  end

  assign slot_stb_o = synced[0] & ~bclk_prev;
  assign frame_o    = synced[1];
  assign data_o     = synced[2];
endmodule

// File: rtl/sar_frame_track.sv
`timescale 1ns/1ps
module sar_frame_track import sar_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_stb_i,
  input  logic              frame_i,
  input  logic              prot_i,
  output logic              half_start_o,
  output logic [SLOT_W-1:0] slot_now_o,
  output logic              closed_lr_o,
  output logic              closed_full_o,
  output logic              bad_o
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(HALF_SLOTS - 1);

  logic [SLOT_W-1:0] cnt_q;
  logic              lr_acc_q, locked_q, bad_q;
  logic              chg, full, accept, early;

  assign chg    = frame_i ^ lr_acc_q;
  assign full   = (cnt_q == LAST);
  assign accept = slot_stb_i & chg & (~locked_q | ~prot_i | full);
  assign early  = slot_stb_i & chg & locked_q & ~full;

  always_comb begin
    if (accept)    slot_now_o = '0;
    else if (full) slot_now_o = LAST;
    else           slot_now_o = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      lr_acc_q <= 1'b0;
      locked_q <= 1'b0;
      bad_q    <= 1'b0;
    end else begin
      bad_q <= early;
      if (slot_stb_i) cnt_q <= slot_now_o;
      if (accept) begin
        lr_acc_q <= frame_i;
        locked_q <= 1'b1;
      end
    end
  end

  assign half_start_o  = accept;
  assign closed_lr_o   = lr_acc_q;
  assign closed_full_o = locked_q;
  assign bad_o         = bad_q;
endmodule

// File: rtl/sar_capture.sv
`timescale 1ns/1ps
module sar_capture import sar_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_stb_i,
  input  logic              half_start_i,
  input  logic [SLOT_W-1:0] slot_now_i,
  input  logic              data_i,
  input  logic              closed_lr_i,
  input  logic              closed_full_i,
  input  logic [3:0]        fmt_i,
  input  logic              lsb_first_i,
  input  logic              dly_i,
  output logic              word_stb_o,
  output logic              word_left_o,
  output word_t             word_o
);
  layout_e          lay;
  logic [IDX_W-1:0] w6, start6, slot6, idx6, pos6;
  logic             in_win, is_left;
  word_t            acc_q, contrib;

  assign lay    = layout_e'(fmt_i[1:0]);
  assign w6     = len_bits(fmt_i[3:2]);
  assign start6 = first_slot(lay, fmt_i[3:2], dly_i);
  assign slot6  = {1'b0, slot_now_i};
  assign in_win = (slot6 >= start6) && (slot6 < start6 + w6);
  assign idx6   = slot6 - start6;
  assign pos6   = lsb_first_i ? (IDX_W'(WORD_W) - w6 + idx6)
                              : (IDX_W'(WORD_W - 1) - idx6);
  assign contrib = in_win ? (word_t'(data_i) << pos6) : '0;
  assign is_left = (lay == LAY_LJ || lay == LAY_RJ) ? closed_lr_i : ~closed_lr_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      word_o      <= '0;
      word_left_o <= 1'b0;
      word_stb_o  <= 1'b0;
    end else begin
      word_stb_o <= 1'b0;
      if (slot_stb_i) begin
        if (half_start_i) begin
          word_o      <= acc_q;
          word_left_o <= is_left;
          word_stb_o  <= closed_full_i;
          acc_q       <= contrib;
        end else begin
          acc_q <= acc_q | contrib;
        end
      end
    end
  end
endmodule

// File: rtl/sar_out_stage.sv
`timescale 1ns/1ps
module sar_out_stage import sar_pkg::*; #(
  parameter int unsigned ZERO_RUN = 2048
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  word_stb_i,
  input  logic  word_left_i,
  input  word_t word_i,
  input  logic  sel1_i,
  input  logic  sel2_i,
  input  logic  zd_en_i,
  input  logic  out_ready_i,
  output logic  out_valid_o,
  output word_t ch1_o,
  output word_t ch2_o,
  output logic  zero_o
);
  localparam int unsigned ZW = $clog2(ZERO_RUN + 1);

  word_t         l_hold_q;
  logic          have_left_q, pair_evt, pair_zero;
  logic [ZW-1:0] zcnt_q;

  assign pair_evt  = word_stb_i & ~word_left_i & have_left_q;
  assign pair_zero = (l_hold_q == '0) && (word_i == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l_hold_q    <= '0;
      have_left_q <= 1'b0;
      out_valid_o <= 1'b0;
      ch1_o       <= '0;
      ch2_o       <= '0;
    end else begin
      if (word_stb_i && word_left_i) begin
        l_hold_q    <= word_i;
        have_left_q <= 1'b1;
      end else if (pair_evt) begin
        have_left_q <= 1'b0;
      end
      if (pair_evt && (!out_valid_o || out_ready_i)) begin
        out_valid_o <= 1'b1;
        ch1_o       <= sel1_i ? word_i : l_hold_q;
        ch2_o       <= sel2_i ? word_i : l_hold_q;
      end else if (out_ready_i) begin
        out_valid_o <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zcnt_q <= '0;
      zero_o <= 1'b0;
    end else if (!zd_en_i) begin
      zcnt_q <= '0;
      zero_o <= 1'b0;
    end else if (pair_evt) begin
      if (pair_zero) begin
        if (zcnt_q != ZW'(ZERO_RUN)) zcnt_q <= zcnt_q + 1'b1;
        zero_o <= (zcnt_q >= ZW'(ZERO_RUN - 1));
      end else begin
        zcnt_q <= '0;
        zero_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/serial_audio_rx.sv
`timescale 1ns/1ps
module serial_audio_rx import sar_pkg::*; #(
  parameter int unsigned ZERO_RUN    = 2048,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bclk_i,
  input  logic        frame_i,
  input  logic        sdata_i,
  input  logic [3:0]  fmt_i,
  input  logic        lsb_first_i,
  input  logic        dly_i,
  input  logic        prot_i,
  input  logic        sel1_i,
  input  logic        sel2_i,
  input  logic        zd_en_i,
  output logic        out_valid_o,
  input  logic        out_ready_i,
  output logic [23:0] ch1_o,
  output logic [23:0] ch2_o,
  output logic        zero_o,
  output logic        bad_frame_o
);
  logic              slot_stb, fr_s, sd_s;
  logic              half_start, closed_lr, closed_full;
  logic [SLOT_W-1:0] slot_now;
  logic              word_stb, word_left;
  word_t             word;

  sar_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk, .rst_n,
    .raw_i      ({sdata_i, frame_i, bclk_i}),
    .slot_stb_o (slot_stb),
    .frame_o    (fr_s),
    .data_o     (sd_s)
  );

  sar_frame_track u_track (
    .clk, .rst_n,
    .slot_stb_i    (slot_stb),
    .frame_i       (fr_s),
    .prot_i        (prot_i),
    .half_start_o  (half_start),
    .slot_now_o    (slot_now),
    .closed_lr_o   (closed_lr),
    .closed_full_o (closed_full),
    .bad_o         (bad_frame_o)
  );

  sar_capture u_cap (
    .clk, .rst_n,
    .slot_stb_i    (slot_stb),
    .half_start_i  (half_start),
    .slot_now_i    (slot_now),
    .data_i        (sd_s),
    .closed_lr_i   (closed_lr),
    .closed_full_i (closed_full),
    .fmt_i         (fmt_i),
    .lsb_first_i   (lsb_first_i),
    .dly_i         (dly_i),
    .word_stb_o    (word_stb),
    .word_left_o   (word_left),
    .word_o        (word)
  );

  sar_out_stage #(.ZERO_RUN(ZERO_RUN)) u_out (
    .clk, .rst_n,
    .word_stb_i  (word_stb),
    .word_left_i (word_left),
    .word_i      (word),
    .sel1_i      (sel1_i),
    .sel2_i      (sel2_i),
    .zd_en_i     (zd_en_i),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .ch1_o       (ch1_o),
    .ch2_o       (ch2_o),
    .zero_o      (zero_o)
  );
endmodule

// File: rtl/serial_audio_rx_chk.sv
`timescale 1ns/1ps
module serial_audio_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid,
  input logic        out_ready,
  input logic [23:0] ch1,
  input logic [23:0] ch2,
  input logic        zero,
  input logic        zd_en,
  input logic        bad,
  input logic        prot,
  input logic        half_start
);
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(ch1) && $stable(ch2)));

  assert_fall_after_transfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));

  assert_zero_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !zd_en |=> !zero);

  assert_bad_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> !bad);

  assert_early_edge_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && $past(prot)) |-> !$past(half_start));
endmodule

bind serial_audio_rx serial_audio_rx_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .out_valid  (out_valid_o),
  .out_ready  (out_ready_i),
  .ch1        (ch1_o),
  .ch2        (ch2_o),
  .zero       (zero_o),
  .zd_en      (zd_en_i),
  .bad        (bad_frame_o),
  .prot       (prot_i),
  .half_start (half_start)
);

// File: tb/serial_audio_rx_tb_top.sv
`timescale 1ns/1ps
module serial_audio_rx_tb_top;
  localparam int ZR = 4;

  logic clk = 0, rst_n = 0, bclk = 0, frame = 0, sdata = 0;
  logic [3:0] fmt = 0;
  logic lsb = 0, dly = 0, prot = 0, sel1 = 0, sel2 = 1, zd_en = 0, ready = 1;
  logic ov, zero, bad;
  logic [23:0] c1, c2;

  int checks = 0, fails = 0, mchecks = 0, mfails = 0, bad_cnt = 0;
  bit chk_en = 1, push_en = 1, done = 0;
  string req = "R2";
  logic [23:0] e1 [256];
  logic [23:0] e2 [256];
  int wr_idx = 0, rd_idx = 0;

  always #5 clk = ~clk;

  serial_audio_rx #(.ZERO_RUN(ZR)) dut_i (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .frame_i(frame), .sdata_i(sdata),
    .fmt_i(fmt), .lsb_first_i(lsb), .dly_i(dly), .prot_i(prot),
    .sel1_i(sel1), .sel2_i(sel2), .zd_en_i(zd_en),
    .out_valid_o(ov), .out_ready_i(ready), .ch1_o(c1), .ch2_o(c2),
    .zero_o(zero), .bad_frame_o(bad));

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic int wlen(logic [1:0] c);
    case (c) 2'b00: return 24; 2'b01: return 20; 2'b10: return 18; default: return 16; endcase
  endfunction

  function automatic int fslot(logic [1:0] lay, int w, logic d);
    int b = (lay == 2'b01) ? 0 : (lay == 2'b10) ? 32 - w : 1;
    return b + int'(d);
  endfunction

  function automatic logic left_level(logic [1:0] lay);
    return (lay == 2'b01 || lay == 2'b10);
  endfunction

  function automatic logic [23:0] expw(logic [23:0] v);
    int w = wlen(fmt[3:2]);
    logic [23:0] e = v << (24 - w);
    if (fmt[1:0] == 2'b10 && dly) e[lsb ? 23 : 24 - w] = 1'b0;
    return e;
  endfunction

  task automatic slot(logic l, logic d);
    frame = l; sdata = d;
    #40 bclk = 1;
    #40 bclk = 0;
  endtask

  task automatic send_half(logic l, logic [23:0] v, int glitch);
    int w = wlen(fmt[3:2]);
    int st = fslot(fmt[1:0], w, dly);
    for (int s = 0; s < 32; s++) begin
      int i = s - st;
      logic b = 1'b0;
      if (i >= 0 && i < w) b = lsb ? v[i] : v[w-1-i];
      slot((s == glitch) ? ~l : l, b);
    end
  endtask

  task automatic push(logic [23:0] l, logic [23:0] r);
    logic [23:0] el = expw(l), er = expw(r);
    e1[wr_idx % 256] = sel1 ? er : el;
    e2[wr_idx % 256] = sel2 ? er : el;
    wr_idx++;
  endtask

  task automatic send_frame(logic [23:0] l, logic [23:0] r, int glitch);
    logic lv = left_level(fmt[1:0]);
    send_half(lv, l, glitch);
    send_half(~lv, r, -1);
    if (chk_en && push_en) push(l, r);
  endtask

  task automatic start_group(string r, logic [3:0] f, logic ls, logic d, logic p,
                             logic s1, logic s2, logic z);
    req = r;
    rst_n = 0; bclk = 0;
    fmt = f; lsb = ls; dly = d; prot = p; sel1 = s1; sel2 = s2; zd_en = z;
    repeat (3) @(posedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    send_half(~left_level(fmt[1:0]), 24'h0, -1);
  endtask

  task automatic end_group(bit drain);
    send_half(left_level(fmt[1:0]), 24'h0, -1);
    repeat (10) @(negedge clk);
    if (drain && chk_en) check("R7 all pairs delivered", rd_idx, wr_idx);
  endtask

  function automatic logic [23:0] rnd(int w);
    return 24'($urandom) & ((24'h1 << w) - 24'h1);
  endfunction

  always @(negedge clk) begin
    if (rst_n && bad) bad_cnt++;
    if (rst_n && ov && ready && chk_en) begin
      mchecks += 2;
      if (rd_idx == wr_idx) begin
        mfails++;
        $display("FAIL %s/R12 unexpected pair actual %h %h expected none", req, c1, c2);
      end else begin
        if (c1 !== e1[rd_idx % 256]) begin
          mfails++;
          $display("FAIL %s ch1 actual %h expected %h", req, c1, e1[rd_idx % 256]);
        end
        if (c2 !== e2[rd_idx % 256]) begin
          mfails++;
          $display("FAIL %s ch2 actual %h expected %h", req, c2, e2[rd_idx % 256]);
        end
        rd_idx++;
      end
    end
  end

  initial begin
    int b0;
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 valid", ov, 0);
    check("R1 zero", zero, 0);
    check("R1 bad", bad, 0);

    // R2 R3: I2S 24-bit MSB first, extreme values
    start_group("R2", 4'b0000, 0, 0, 0, 0, 1, 0);
    send_frame(24'h800001, 24'h7FFFFE, -1);
    send_frame(24'h123456, 24'hABCDEF, -1);
    end_group(1);
    check("R10 clean frames no pulse", bad_cnt, 0);

    // R3: left-justified 20-bit
    start_group("R3", 4'b0101, 0, 0, 0, 0, 1, 0);
    send_frame(24'h80001, 24'h7FFFF, -1);
    end_group(1);

    // R4: left-justified 16-bit LSB first, right-justified 18-bit LSB first
    start_group("R4", 4'b1101, 1, 0, 0, 0, 1, 0);
    send_frame(24'h8001, 24'h1234, -1);
    end_group(1);
    start_group("R4", 4'b1010, 1, 0, 0, 0, 1, 0);
    send_frame(24'h20001, 24'h3FFFF, -1);
    end_group(1);

    // R5: delayed capture, including truncated right-justified case
    start_group("R5", 4'b0000, 0, 1, 0, 0, 1, 0);
    send_frame(24'hC00003, 24'h5A5A5A, -1);
    end_group(1);
    start_group("R5", 4'b0110, 0, 1, 0, 0, 1, 0);
    send_frame(24'hFFFFF, 24'h80001, -1);
    end_group(1);

    // R6: channel routing
    start_group("R6", 4'b0000, 0, 0, 0, 1, 0, 0);
    send_frame(24'h111111, 24'h222222, -1);
    end_group(1);
    start_group("R6", 4'b0001, 0, 0, 0, 1, 1, 0);
    send_frame(24'h333333, 24'h444444, -1);
    end_group(1);

    // R7: back-pressure holds first pair, drops later ones
    start_group("R7", 4'b0000, 0, 0, 0, 0, 1, 0);
    ready = 0;
    send_frame(24'h0A0B0C, 24'h0D0E0F, -1);
    push_en = 0;
    send_frame(24'h999999, 24'h888888, -1);
    send_frame(24'h777777, 24'h666666, -1);
    push_en = 1;
    end_group(0);
    check("R7 held valid", ov, 1);
    check("R7 held ch1", c1, e1[rd_idx % 256]);
    check("R7 held ch2", c2, e2[rd_idx % 256]);
    ready = 1;
    repeat (4) @(negedge clk);
    check("R7 drained", rd_idx, wr_idx);
    check("R7 valid low after transfer", ov, 0);

    // R8: zero run
    start_group("R8", 4'b0000, 0, 0, 0, 0, 1, 1);
    for (int k = 0; k < ZR - 1; k++) send_frame(24'h0, 24'h0, -1);
    end_group(1);
    check("R8 not yet zero", zero, 0);
    start_group("R8", 4'b0000, 0, 0, 0, 0, 1, 1);
    for (int k = 0; k < ZR; k++) send_frame(24'h0, 24'h0, -1);
    end_group(1);
    check("R8 zero after run", zero, 1);
    send_half(1'b1, 24'h000001, -1);
    push(24'h0, 24'h000001);
    send_half(1'b0, 24'h0, -1);
    repeat (10) @(negedge clk);
    check("R8 cleared by nonzero", zero, 0);

    // R9: disabled detection
    start_group("R9", 4'b0000, 0, 0, 0, 0, 1, 1);
    for (int k = 0; k < ZR; k++) send_frame(24'h0, 24'h0, -1);
    end_group(1);
    check("R9 armed", zero, 1);
    zd_en = 0;
    repeat (2) @(negedge clk);
    check("R9 forced low", zero, 0);

    // R10 R11: glitch with protection
    start_group("R11", 4'b0000, 0, 0, 1, 0, 1, 0);
    send_frame(24'h13579B, 24'h2468AC, -1);
    send_frame(24'hFEDCBA, 24'h0F0F0F, 10);
    send_frame(24'h765432, 24'h111000, -1);
    end_group(1);
    check("R10 one pulse on glitch", bad_cnt, 1);

    // R10: glitch without protection still flagged
    chk_en = 0;
    start_group("R10", 4'b0000, 0, 0, 0, 0, 1, 0);
    b0 = bad_cnt;
    send_frame(24'h123456, 24'h654321, 10);
    end_group(0);
    check("R10 flagged unprotected", (bad_cnt > 0) ? 1 : 0, 1);
    chk_en = 1;
    rd_idx = 0; wr_idx = 0;

    // random groups
    for (int g = 0; g < 10; g++) begin
      logic [3:0] f = 4'($urandom);
      start_group("R3 random", f, 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 0);
      for (int k = 0; k < 4; k++)
        send_frame(rnd(wlen(f[3:2])), rnd(wlen(f[3:2])), -1);
      end_group(1);
    end
    done = 1;
  end

  initial begin
    int n = 0;
    while (!done && n < 190000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual timeout expected completion");
    end
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures",
             checks + mchecks, fails + mfails);
    $finish;
  end
endmodule